// File: doc/BRIEF.md
# Power-Management Register Bank with Interrupt Controller

This block is the register bank of a power-management companion device. Its word width is 16 bits and a 5-bit index selects the register. A single-cycle write strobe with index and data changes state. Read data comes back combinationally for whatever index is presented, and reads have no side effects. The bank holds several pieces of state:

- a maskable interrupt controller, whose pending bits are toggled by software writes and set by hardware events;
- an ADC channel selector with a small result store;
- per-channel sample-ready flags that software clears by writing ones;
- two general control words, an RTC calibration word and a read-only status word;
- a watchdog register that can request a system shutdown.

Hardware feeds the bank through two side inputs. A power-key event input carries the key level. An ADC result port loads a conversion result into one channel. A strap input selects the device variant reported in the identification word. Index positions that are not implemented read as zero and ignore writes.

Top module: `pmic_regbank`

## Requirements
- R1: After synchronous reset the mask reads 0xFFFF, pending 0x0000, status 0x0020, RTC calibration 0x0001, both control words 0x0000, and `irq` and `shutdown_req` are low.
- R2: Index 0x00 reads 0x0215 with bit 7 equal to `variant_sel`; writes to it are ignored.
- R3: A write to index 0x01 (pending) replaces the pending word with its XOR with the written data.
- R4: `irq` is high exactly when some pending bit is 1 whose mask bit (index 0x02, read/write, 1 = disabled) is 0.
- R5: Index 0x08 reads the selected channel in bits 13:10 and that channel's 10-bit result in bits 9:0. A write selects the channel from bits 13:10 and sets pending bit 8. A channel never loaded reads result 0.
- R6: A result-port load stores the value for its channel and sets bit `chan` of the sample word (index 0x09). A write to 0x09 clears every bit written as 1. In the same cycle, a load takes priority over the clear.
- R7: A key event sets pending bit 0. It also makes status bit 5 (index 0x16) 0 if `key_down` is high and 1 if it is low.
- R8: Writing 0x0000 to index 0x17 while bit 1 of control word 1 is set raises `shutdown_req` for one cycle, starting in the cycle after the write. Any other value, or that bit clear, gives no request.
- R9: RTC calibration (0x06), control 1 (0x0D) and control 2 (0x0E) are full 16-bit read/write registers.
- R10: Unmapped indices, the watchdog index and the status index read 0x0000 (status: its live value). Writes to any of them change no register.
- R11: When a hardware set of a pending bit and a software XOR hit the same bit in one cycle, the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Variant strap reflected in ID bit 7 |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_idx | input | 5 | Register index for read and write |
| acc_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `acc_idx` |
| key_evt | input | 1 | Power-key event pulse |
| key_down | input | 1 | Key level with the event, 1 = pressed |
| res_wr | input | 1 | ADC result load strobe |
| res_chan | input | 4 | Channel for the result load |
| res_val | input | 10 | Result value |
| irq | output | 1 | Interrupt request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the block with its default parameters: 16 ADC channels and 10-bit results. This puts the top channel (15) and the full-scale result 0x3FF within reach, so the channel field and the result field are both driven to all ones together. It also means bits 15:14 of an ADC write have to be discarded. With 16 channels the sample word fills the whole register, so the clear-by-ones behaviour is seen on the most significant bit as well as the low bits.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

    localparam int REG_W = 16;
    localparam int IDX_W = 5;

    typedef enum logic [IDX_W-1:0] {
        IX_ID       = 5'h00,
        IX_IRQ_PEND = 5'h01,
        IX_IRQ_MASK = 5'h02,
        IX_RTC_CAL  = 5'h06,
        IX_ADC      = 5'h08,
        IX_SAMPLE   = 5'h09,
        IX_CTRL1    = 5'h0D,
        IX_CTRL2    = 5'h0E,
        IX_STATUS   = 5'h16,
        IX_WDOG     = 5'h17
    } reg_idx_e;

    localparam logic [REG_W-1:0] RST_MASK = 16'hFFFF;
    localparam logic [REG_W-1:0] RST_CAL  = 16'h0001;
    localparam logic [REG_W-1:0] ID_BASE  = 16'h0215;

    localparam int ID_VARIANT_BIT = 7;
    localparam int IRQ_BIT_KEY    = 0;
    localparam int IRQ_BIT_ADC    = 8;
    localparam int STAT_KEY_BIT   = 5;
    localparam int WDOG_EN_BIT    = 1;
    localparam int ADC_CH_LSB     = 10;

    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] data;
    } bus_wr_t;

    function automatic logic hit(bus_wr_t w, logic [IDX_W-1:0] ix);
        return w.wr && (w.idx == ix);
    endfunction

    function automatic logic [REG_W-1:0] id_word(logic variant);
        logic [REG_W-1:0] v;
        v = ID_BASE;
        v[ID_VARIANT_BIT] = variant;
        return v;
    endfunction

endpackage

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl
    import pmic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_wr_t          bw,
    input  logic             key_set,
    input  logic             adc_set,
    output logic [REG_W-1:0] pend,
    output logic [REG_W-1:0] mask,
    output logic             irq
);

    logic [REG_W-1:0] pend_q, mask_q, pend_d;
    logic             pend_wr;

    assign pend_wr = hit(bw, IX_IRQ_PEND);

    always_comb begin
        pend_d = pend_q;
        if (pend_wr) pend_d = pend_q ^ bw.data;
        if (key_set) pend_d[IRQ_BIT_KEY] = 1'b1;
        if (adc_set) pend_d[IRQ_BIT_ADC] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= RST_MASK;
        end else begin
            pend_q <= pend_d;
            if (hit(bw, IX_IRQ_MASK)) mask_q <= bw.data;
        end
    end

    assign pend = pend_q;
    assign mask = mask_q;
    assign irq  = |(pend_q & ~mask_q);

    AST_KEY_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        key_set |=> pend[IRQ_BIT_KEY]); // R7
    AST_ADC_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        adc_set |=> pend[IRQ_BIT_ADC]); // R5
    AST_SET_BEATS_XOR: assert property (@(posedge clk) disable iff (rst)
        (key_set && pend_wr) |=> pend[IRQ_BIT_KEY]); // R11
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!pend_wr && !key_set && !adc_set) |=> $stable(pend)); // R3
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq); // R4

endmodule

// File: rtl/pmic_adc_store.sv
module pmic_adc_store
    import pmic_pkg::*;
#(
    parameter  int ADC_CH    = 16,
    parameter  int ADC_RES_W = 10,
    localparam int CH_W      = $clog2(ADC_CH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_wr_t              bw,
    input  logic                 res_wr,
    input  logic [CH_W-1:0]      res_chan,
    input  logic [ADC_RES_W-1:0] res_val,
    output logic [REG_W-1:0]     adc_word,
    output logic [REG_W-1:0]     sample_word,
    output logic                 sel_wr
);

    logic [ADC_RES_W-1:0] res_q [ADC_CH];
    logic [ADC_CH-1:0]    samp_q;
    logic [CH_W-1:0]      sel_q;
    logic                 samp_wr;

    assign sel_wr  = hit(bw, IX_ADC);
    assign samp_wr = hit(bw, IX_SAMPLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            samp_q <= '0;
            for (int c = 0; c < ADC_CH; c++) res_q[c] <= '0;
        end else begin
            if (sel_wr) sel_q <= bw.data[ADC_CH_LSB +: CH_W];
            for (int c = 0; c < ADC_CH; c++) begin
                if (res_wr && res_chan == CH_W'(c)) begin
                    res_q[c]  <= res_val;
                    samp_q[c] <= 1'b1;
                end else if (samp_wr && bw.data[c]) begin
                    samp_q[c] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        adc_word = '0;
        adc_word[ADC_RES_W-1:0]      = res_q[sel_q];
        adc_word[ADC_CH_LSB +: CH_W] = sel_q;
    end

    assign sample_word = REG_W'(samp_q);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (samp_wr && !res_wr) |=> ((samp_q & $past(bw.data[ADC_CH-1:0])) == '0)); // R6
    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        res_wr |=> samp_q[$past(res_chan)]); // R6
    AST_SEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (sel_q == $past(bw.data[ADC_CH_LSB +: CH_W]))); // R5

endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
    import pmic_pkg::*;
#(
    parameter int ADC_CH    = 16,
    parameter int ADC_RES_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       variant_sel,
    input  logic                       acc_wr,
    input  logic [4:0]                 acc_idx,
    input  logic [15:0]                acc_wdata,
    output logic [15:0]                rd_data,
    input  logic                       key_evt,
    input  logic                       key_down,
    input  logic                       res_wr,
    input  logic [$clog2(ADC_CH)-1:0]  res_chan,
    input  logic [ADC_RES_W-1:0]       res_val,
    output logic                       irq,
    output logic                       shutdown_req
);

    bus_wr_t          bw;
    logic [REG_W-1:0] pend, mask, adc_word, sample_word;
    logic [REG_W-1:0] cal_q, ctrl1_q, ctrl2_q, status_word;
    logic             key_up_q, shdn_q, adc_sel_wr;

    assign bw = '{wr: acc_wr, idx: acc_idx, data: acc_wdata};

    pmic_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .bw      (bw),
        .key_set (key_evt),
        .adc_set (adc_sel_wr),
        .pend    (pend),
        .mask    (mask),
        .irq     (irq)
    );

    pmic_adc_store #(
        .ADC_CH    (ADC_CH),
        .ADC_RES_W (ADC_RES_W)
    ) u_adc (
        .clk         (clk),
        .rst         (rst),
        .bw          (bw),
        .res_wr      (res_wr),
        .res_chan    (res_chan),
        .res_val     (res_val),
        .adc_word    (adc_word),
        .sample_word (sample_word),
        .sel_wr      (adc_sel_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q    <= RST_CAL;
            ctrl1_q  <= '0;
            ctrl2_q  <= '0;
            key_up_q <= 1'b1;
            shdn_q   <= 1'b0;
        end else begin
            if (hit(bw, IX_RTC_CAL)) cal_q   <= bw.data;
            if (hit(bw, IX_CTRL1))   ctrl1_q <= bw.data;
            if (hit(bw, IX_CTRL2))   ctrl2_q <= bw.data;
            if (key_evt)             key_up_q <= ~key_down;
            shdn_q <= hit(bw, IX_WDOG) && (bw.data == '0) && ctrl1_q[WDOG_EN_BIT];
        end
    end

    always_comb begin
        status_word = '0;
        status_word[STAT_KEY_BIT] = key_up_q;
    end

    always_comb begin
        case (acc_idx)
            IX_ID:       rd_data = id_word(variant_sel);
            IX_IRQ_PEND: rd_data = pend;
            IX_IRQ_MASK: rd_data = mask;
            IX_RTC_CAL:  rd_data = cal_q;
            IX_ADC:      rd_data = adc_word;
            IX_SAMPLE:   rd_data = sample_word;
            IX_CTRL1:    rd_data = ctrl1_q;
            IX_CTRL2:    rd_data = ctrl2_q;
            IX_STATUS:   rd_data = status_word;
            default:     rd_data = '0;
        endcase
    end

    assign shutdown_req = shdn_q;

    AST_SHDN_ARMED: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(acc_wr && acc_idx == IX_WDOG && acc_wdata == '0
                               && ctrl1_q[WDOG_EN_BIT])); // R8
    AST_KEY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        key_evt |=> (key_up_q == !$past(key_down))); // R7
    AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(acc_wr && acc_idx == IX_RTC_CAL) |=> $stable(cal_q)); // R9

endmodule

// File: tb/sim_pmic_regbank.sv
`timescale 1ns/1ps
module sim_pmic_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        variant_sel = 1'b0;
    logic        acc_wr = 1'b0;
    logic [4:0]  acc_idx = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_data;
    logic        key_evt = 1'b0;
    logic        key_down = 1'b0;
    logic        res_wr = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [9:0]  res_val = '0;
    logic        irq, shutdown_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pmic_regbank u0 (
        .clk(clk), .rst(rst), .variant_sel(variant_sel),
        .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .key_evt(key_evt), .key_down(key_down),
        .res_wr(res_wr), .res_chan(res_chan), .res_val(res_val),
        .irq(irq), .shutdown_req(shutdown_req)
    );

    // {index, write data, expected read-back}
    localparam logic [36:0] VEC [8] = '{
        {5'h06, 16'hA5A5, 16'hA5A5},
        {5'h0D, 16'h1234, 16'h1234},
        {5'h0E, 16'hFFFF, 16'hFFFF},
        {5'h02, 16'h0F0F, 16'h0F0F},
        {5'h00, 16'hFFFF, 16'h0215},
        {5'h03, 16'hBEEF, 16'h0000},
        {5'h1F, 16'hBEEF, 16'h0000},
        {5'h16, 16'h0000, 16'h0020}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [15:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, output logic [15:0] v);
        acc_idx = idx;
        #1;
        v = rd_data;
    endtask

    task automatic key(input logic down, input logic with_xor);
        @(negedge clk);
        key_evt = 1'b1; key_down = down;
        if (with_xor) begin
            acc_wr = 1'b1; acc_idx = 5'h01; acc_wdata = 16'h0001;
        end
        @(posedge clk);
        @(negedge clk);
        key_evt = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic load(input logic [3:0] ch, input logic [9:0] v);
        @(negedge clk);
        res_wr = 1'b1; res_chan = ch; res_val = v;
        @(posedge clk);
        @(negedge clk);
        res_wr = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h02, v); chk("R1 mask", v, 16'hFFFF);
        rd(5'h01, v); chk("R1 pend", v, 16'h0000);
        rd(5'h16, v); chk("R1 status", v, 16'h0020);
        rd(5'h06, v); chk("R1 cal", v, 16'h0001);
        rd(5'h0D, v); chk("R1 ctrl1", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 shutdown", {15'd0, shutdown_req}, 16'd0);

        // R2 variant strap
        rd(5'h00, v); chk("R2 id v0", v, 16'h0215);
        variant_sel = 1'b1;
        rd(5'h00, v); chk("R2 id v1", v, 16'h0295);
        variant_sel = 1'b0;

        // table walk: R2 R4 R9 R10
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][36:32], VEC[i][31:16]);
            rd(VEC[i][36:32], v);
            chk("R2 R4 R9 R10 table", v, VEC[i][15:0]);
        end
        // R10: unmapped writes left the other registers intact
        rd(5'h06, v); chk("R10 cal intact", v, 16'hA5A5);
        rd(5'h17, v); chk("R10 wdog reads 0", v, 16'h0000);

        // R3 XOR into pending, R4 masking
        wr(5'h02, 16'hFFFF);
        wr(5'h01, 16'h00F0); rd(5'h01, v); chk("R3 xor set", v, 16'h00F0);
        wr(5'h01, 16'h0030); rd(5'h01, v); chk("R3 xor toggle", v, 16'h00C0);
        chk("R4 all masked", {15'd0, irq}, 16'd0);
        wr(5'h02, 16'hFF7F); chk("R4 unmasked", {15'd0, irq}, 16'd1);
        wr(5'h02, 16'hFFBF); chk("R4 unmasked b6", {15'd0, irq}, 16'd1);
        wr(5'h01, 16'h00C0); rd(5'h01, v); chk("R3 cleared", v, 16'h0000);
        chk("R4 no pending", {15'd0, irq}, 16'd0);

        // R5 ADC register
        wr(5'h08, 16'h0C00); rd(5'h08, v); chk("R5 unloaded chan", v, 16'h0C00);
        rd(5'h01, v); chk("R5 done bit", v, 16'h0100);
        wr(5'h02, 16'hFEFF); chk("R5 R4 done irq", {15'd0, irq}, 16'd1);
        wr(5'h01, 16'h0100); chk("R5 irq cleared", {15'd0, irq}, 16'd0);
        load(4'd15, 10'h3FF);
        wr(5'h08, 16'hFFFF); rd(5'h08, v); chk("R5 top chan full", v, 16'h3FFF);
        load(4'd2, 10'h0FC);
        wr(5'h08, 16'h0800); rd(5'h08, v); chk("R5 chan2", v, 16'h08FC);

        // R6 sample flags
        rd(5'h09, v); chk("R6 flags set", v, 16'h8004);
        wr(5'h09, 16'h0004); rd(5'h09, v); chk("R6 clear one", v, 16'h8000);
        wr(5'h09, 16'h0000); rd(5'h09, v); chk("R6 zero write", v, 16'h8000);
        wr(5'h09, 16'h8000); rd(5'h09, v); chk("R6 clear msb", v, 16'h0000);

        // R7 power key
        wr(5'h01, 16'h0100);
        key(1'b1, 1'b0);
        rd(5'h01, v); chk("R7 key pend", v, 16'h0001);
        rd(5'h16, v); chk("R7 pressed", v, 16'h0000);
        key(1'b0, 1'b0);
        rd(5'h16, v); chk("R7 released", v, 16'h0020);
        wr(5'h01, 16'h0001); rd(5'h01, v); chk("R7 pend clear", v, 16'h0000);

        // R11 set wins over XOR
        key(1'b0, 1'b1);
        rd(5'h01, v); chk("R11 set wins", v, 16'h0001);

        // R8 watchdog
        wr(5'h0D, 16'h0000);
        wr(5'h17, 16'h0000); chk("R8 disarmed", {15'd0, shutdown_req}, 16'd0);
        wr(5'h0D, 16'h0002);
        wr(5'h17, 16'h0001); chk("R8 nonzero", {15'd0, shutdown_req}, 16'd0);
        wr(5'h17, 16'h0000); chk("R8 armed pulse", {15'd0, shutdown_req}, 16'd1);
        @(negedge clk); chk("R8 pulse ends", {15'd0, shutdown_req}, 16'd0);
        rd(5'h17, v); chk("R8 R10 wdog read", v, 16'h0000);

        finish_run();
    end

endmodule